// File: doc/BRIEF.md
# Burst Staging Buffer with Bandwidth Error Detection

This block sits between a stereo sample source and a memory bus. It gathers incoming stereo samples into a 64-byte staging block. Once the block holds 16 samples, it raises a burst request. After a grant it sends the block as 16 back-to-back 32-bit words, oldest sample first. Each word carries the left channel in its upper half and the right channel in its lower half.

While a full block waits for the bus or is being sent, one more sample can be parked in a single holding register. When the burst completes, that parked sample becomes the first entry of the next block. If a second sample arrives while the holding register is occupied and the block is still unsent, the bus has not kept pace with the sample rate. In that case the sample is discarded and a sticky bandwidth-error flag is raised. The flag stays set until an acknowledge pulse clears it.

Address generation and buffer switching belong to the controller that drives this block.

Top module: `bsb_stage`

## Requirements
- R1: After synchronous reset, `bus_req`, `bus_wvalid`, `bus_wlast` and `bw_err` are all 0.
- R2: `bus_req` rises in the cycle after the 16th sample of a block is accepted, and not earlier.
- R3: `bus_req` stays high until it is sampled together with `bus_gnt`. In the next cycle `bus_req` is low and `bus_wvalid` is high.
- R4: A burst has exactly 16 consecutive cycles with `bus_wvalid` high. `bus_wlast` is high only on the 16th of these cycles.
- R5: Burst words appear in sample arrival order. Each word is {left[15:0], right[15:0]}, so left occupies bits 31:16.
- R6: A sample that arrives while the block is unsent and the holding register is full sets `bw_err` in the next cycle. That sample never appears on the bus.
- R7: `bw_err` stays set until `bw_err_ack` is pulsed, and it reads 0 in the cycle after the pulse. If a new error coincides with the pulse, the error takes precedence.
- R8: A sample parked in the holding register becomes the first word of the following block.
- R9: A single sample that arrives while a block is unsent does not set `bw_err`.
- R10: A sample that arrives in the cycle of the final burst word, with the holding register empty, is kept as the first word of the following block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | A sample is presented this cycle |
| smp_left | input | 16 | Left channel sample |
| smp_right | input | 16 | Right channel sample |
| bus_req | output | 1 | Full block waiting for the bus |
| bus_gnt | input | 1 | Bus grant, honoured while `bus_req` is high |
| bus_wvalid | output | 1 | Burst word valid |
| bus_wdata | output | 32 | Burst word {left, right} |
| bus_wlast | output | 1 | Final word of the burst |
| bw_err | output | 1 | Sticky bandwidth error |
| bw_err_ack | input | 1 | Pulse to clear `bw_err` |

## Verification
A wrong fill counter shows up first on `bus_req`. The request rises one cycle too early or too late relative to the 16th accepted sample, and the next burst then carries shifted or stale words. A lost or duplicated holding-register sample appears as a mismatch in the first word of the following burst, at most one block after the fault. A mistimed error decision shows up on `bw_err` one cycle after the offending sample, either as a spurious set or as a missing set together with an extra word on the bus.

// File: rtl/bsb_pkg.sv
package bsb_pkg;

    parameter int unsigned SMP_W = 16;

    typedef struct packed {
        logic [SMP_W-1:0] left;
        logic [SMP_W-1:0] right;
    } stereo_t;

    localparam int unsigned WORD_W = $bits(stereo_t);

    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_PEND  = 2'd1,
        ST_BURST = 2'd2
    } stage_e;

    function automatic stereo_t make_sample(logic [SMP_W-1:0] l, logic [SMP_W-1:0] r);
        stereo_t s;
        s.left  = l;
        s.right = r;
        return s;
    endfunction

endpackage

// File: rtl/bsb_block_mem.sv
module bsb_block_mem
    import bsb_pkg::*;
#(
    parameter int unsigned WORDS = 16,
    localparam int unsigned IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  stereo_t          wdata,
    input  logic [IDX_W-1:0] raddr,
    output stereo_t          rdata
);

    stereo_t mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/bsb_ctrl.sv
module bsb_ctrl
    import bsb_pkg::*;
#(
    parameter int unsigned WORDS = 16,
    localparam int unsigned IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  stereo_t          in_smp,
    input  logic             gnt,
    input  logic             err_ack,
    output logic             req,
    output logic             beat_valid,
    output logic             beat_last,
    output logic [IDX_W-1:0] beat_idx,
    output logic             mem_we,
    output logic [IDX_W-1:0] mem_waddr,
    output stereo_t          mem_wdata,
    output logic             err
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    stage_e           state_q;
    logic [IDX_W-1:0] fill_q;
    logic [IDX_W-1:0] beat_q;
    logic             hold_full_q;
    stereo_t          hold_q;
    logic             err_q;

    logic busy;
    logic done;
    logic err_hit;

    assign busy    = (state_q != ST_FILL);
    assign done    = (state_q == ST_BURST) && (beat_q == LAST_IDX);
    assign err_hit = busy && in_valid && hold_full_q;

    // storage write port: normal fill, or seed of the next block at burst end
    always_comb begin
        mem_we    = 1'b0;
        mem_waddr = fill_q;
        mem_wdata = in_smp;
        if (state_q == ST_FILL) begin
            mem_we = in_valid;
        end else if (done) begin
            mem_waddr = '0;
            if (hold_full_q) begin
                mem_we    = 1'b1;
                mem_wdata = hold_q;
            end else begin
                mem_we = in_valid;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_FILL;
            fill_q      <= '0;
            beat_q      <= '0;
            hold_full_q <= 1'b0;
            hold_q      <= '0;
        end else begin
            case (state_q)
                ST_FILL: begin
                    if (in_valid) begin
                        if (fill_q == LAST_IDX) begin
                            fill_q  <= '0;
                            state_q <= ST_PEND;
                        end else begin
                            fill_q <= fill_q + 1'b1;
                        end
                    end
                end
                ST_PEND: begin
                    if (gnt) begin
                        state_q <= ST_BURST;
                        beat_q  <= '0;
                    end
                end
                ST_BURST: begin
                    if (done) begin
                        state_q <= ST_FILL;
                        fill_q  <= (hold_full_q || in_valid) ? IDX_W'(1) : '0;
                    end else begin
                        beat_q <= beat_q + 1'b1;
                    end
                end
                default: state_q <= ST_FILL;
            endcase

            if (done) begin
                hold_full_q <= 1'b0;
            end else if (busy && in_valid && !hold_full_q) begin
                hold_full_q <= 1'b1;
                hold_q      <= in_smp;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (err_hit) begin
            err_q <= 1'b1;
        end else if (err_ack) begin
            err_q <= 1'b0;
        end
    end

    assign req        = (state_q == ST_PEND);
    assign beat_valid = (state_q == ST_BURST);
    assign beat_last  = done;
    assign beat_idx   = beat_q;
    assign err        = err_q;

endmodule

// File: rtl/bsb_stage.sv
module bsb_stage
    import bsb_pkg::*;
#(
    parameter int unsigned BLOCK_BYTES = 64,
    localparam int unsigned WORDS = BLOCK_BYTES * 8 / WORD_W,
    localparam int unsigned IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_left,
    input  logic [SMP_W-1:0]  smp_right,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_wvalid,
    output logic [WORD_W-1:0] bus_wdata,
    output logic              bus_wlast,
    output logic              bw_err,
    input  logic              bw_err_ack
);

    stereo_t          in_smp;
    stereo_t          rd_smp;
    stereo_t          wr_smp;
    logic             we;
    logic [IDX_W-1:0] waddr;
    logic [IDX_W-1:0] raddr;

    assign in_smp = make_sample(smp_left, smp_right);

    bsb_ctrl #(.WORDS(WORDS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (smp_valid),
        .in_smp     (in_smp),
        .gnt        (bus_gnt),
        .err_ack    (bw_err_ack),
        .req        (bus_req),
        .beat_valid (bus_wvalid),
        .beat_last  (bus_wlast),
        .beat_idx   (raddr),
        .mem_we     (we),
        .mem_waddr  (waddr),
        .mem_wdata  (wr_smp),
        .err        (bw_err)
    );

    bsb_block_mem #(.WORDS(WORDS)) u_mem (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (wr_smp),
        .raddr (raddr),
        .rdata (rd_smp)
    );

    assign bus_wdata = rd_smp;

endmodule

// File: rtl/bsb_stage_chk.sv
module bsb_stage_chk #(
    parameter int unsigned WORDS = 16
) (
    input logic clk,
    input logic rst,
    input logic smp_valid,
    input logic bus_req,
    input logic bus_gnt,
    input logic bus_wvalid,
    input logic bus_wlast,
    input logic bw_err,
    input logic bw_err_ack
);

    int unsigned beat_cnt;

    always_ff @(posedge clk) begin
        if (rst || bus_wlast) begin
            beat_cnt <= 0;
        end else if (bus_wvalid) begin
            beat_cnt <= beat_cnt + 1;
        end
    end

    p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_gnt |=> bus_req);

    p_gnt_starts_burst_r3: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_gnt |=> bus_wvalid && !bus_req);

    p_burst_contiguous_r4: assert property (@(posedge clk) disable iff (rst)
        bus_wvalid && !bus_wlast |=> bus_wvalid);

    p_last_position_r4: assert property (@(posedge clk) disable iff (rst)
        bus_wvalid |-> (bus_wlast == (beat_cnt == WORDS - 1)));

    p_last_ends_r4: assert property (@(posedge clk) disable iff (rst)
        bus_wlast |=> !bus_wvalid);

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        bw_err && !bw_err_ack |=> bw_err);

    p_err_needs_busy_r6: assert property (@(posedge clk) disable iff (rst)
        !bw_err && !(smp_valid && (bus_req || bus_wvalid)) |=> !bw_err);

    p_req_not_in_burst_r3: assert property (@(posedge clk) disable iff (rst)
        bus_wvalid |-> !bus_req);

endmodule

bind bsb_stage bsb_stage_chk #(.WORDS(WORDS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .smp_valid  (smp_valid),
    .bus_req    (bus_req),
    .bus_gnt    (bus_gnt),
    .bus_wvalid (bus_wvalid),
    .bus_wlast  (bus_wlast),
    .bw_err     (bw_err),
    .bw_err_ack (bw_err_ack)
);

// File: tb/bsb_stage_bench.sv
module bsb_stage_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_left = '0;
    logic [15:0] smp_right = '0;
    logic        bus_req;
    logic        bus_gnt = 1'b0;
    logic        bus_wvalid;
    logic [31:0] bus_wdata;
    logic        bus_wlast;
    logic        bw_err;
    logic        bw_err_ack = 1'b0;

    int tests = 0;
    int fails = 0;
    int beat  = 0;
    bit done  = 1'b0;
    logic [31:0] expq [$];
    logic [15:0] seq = 16'h0100;

    always #2.5 clk = ~clk;

    bsb_stage u_bsb_stage (
        .clk        (clk),
        .rst        (rst),
        .smp_valid  (smp_valid),
        .smp_left   (smp_left),
        .smp_right  (smp_right),
        .bus_req    (bus_req),
        .bus_gnt    (bus_gnt),
        .bus_wvalid (bus_wvalid),
        .bus_wdata  (bus_wdata),
        .bus_wlast  (bus_wlast),
        .bw_err     (bw_err),
        .bw_err_ack (bw_err_ack)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // driver: presents one sample for one cycle; keep=1 pushes it to the scoreboard
    task automatic send(bit keep);
        logic [15:0] l = seq;
        logic [15:0] r = ~seq;
        seq++;
        smp_valid = 1'b1;
        smp_left  = l;
        smp_right = r;
        if (keep) expq.push_back({l, r});
        @(posedge clk); #1;
        smp_valid = 1'b0;
    endtask

    // monitor: pops expected words as bursts appear (R5), checks last flag (R4)
    always @(negedge clk) begin
        if (!rst && bus_wvalid) begin
            if (expq.size() == 0) begin
                check("R6 unexpected word", bus_wdata, 32'hx);
            end else begin
                check("R5 word", bus_wdata, expq.pop_front());
            end
            check("R4 last flag", 32'(bus_wlast), 32'(beat == 15));
            beat = bus_wlast ? 0 : beat + 1;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 req", 32'(bus_req), 0);
        check("R1 wvalid", 32'(bus_wvalid), 0);
        check("R1 err", 32'(bw_err), 0);
        rst = 1'b0;

        // block 1: grant always available
        bus_gnt = 1'b1;
        for (int i = 0; i < 15; i++) send(1'b1);
        check("R2 req early", 32'(bus_req), 0);
        send(1'b1);
        check("R2 req rise", 32'(bus_req), 1);
        @(posedge clk); #1;
        check("R3 burst start", 32'(bus_wvalid), 1);
        check("R3 req drop", 32'(bus_req), 0);
        repeat (20) @(posedge clk); #1;

        // block 2: grant withheld, overflow
        bus_gnt = 1'b0;
        for (int i = 0; i < 16; i++) send(1'b1);
        repeat (4) @(posedge clk); #1;
        check("R3 req held", 32'(bus_req), 1);
        check("R3 no burst", 32'(bus_wvalid), 0);
        send(1'b1);
        check("R9 single parked", 32'(bw_err), 0);
        send(1'b0);
        check("R6 err set", 32'(bw_err), 1);
        repeat (3) @(posedge clk); #1;
        check("R7 err sticky", 32'(bw_err), 1);
        bw_err_ack = 1'b1;
        @(posedge clk); #1;
        bw_err_ack = 1'b0;
        check("R7 err cleared", 32'(bw_err), 0);
        bus_gnt = 1'b1;
        repeat (20) @(posedge clk); #1;
        check("R8 parked pending", 32'(expq.size()), 1);
        for (int i = 0; i < 15; i++) send(1'b1);
        repeat (20) @(posedge clk); #1;

        // block 4: sample in the final-beat cycle
        bus_gnt = 1'b0;
        for (int i = 0; i < 16; i++) send(1'b1);
        bus_gnt = 1'b1;
        while (!bus_wlast) @(negedge clk);
        smp_valid = 1'b1;
        smp_left  = 16'hBEEF;
        smp_right = 16'h1234;
        expq.push_back({16'hBEEF, 16'h1234});
        @(posedge clk); #1;
        smp_valid = 1'b0;
        check("R10 no err", 32'(bw_err), 0);
        for (int i = 0; i < 15; i++) send(1'b1);
        repeat (22) @(posedge clk); #1;
        check("R10 scoreboard drained", 32'(expq.size()), 0);
        check("R6 err still clear", 32'(bw_err), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule